// File: doc/BRIEF.md
# Serial NOR Flash Sector Rewrite Sequencer

This block rewrites one 4 KiB sector of a serial NOR flash over a single-lane SPI link. It is the master on the link: it drives SCLK, MOSI and an active-low chip select, and it samples MISO. A one-cycle `start` pulse with a 12-bit sector number begins a run. The block first erases the sector. It then programs the sector as sixteen 256-byte pages. It fetches every data byte from a local sector buffer through a read port with one-cycle latency. A run ends with exactly one of `done`, `timeout` or `error` raised, and that flag stays up until the next accepted start.

Every erase and every page program is bracketed the same way. First comes a write-enable frame. Then status reads repeat until the write-enable latch (status bit 1) reads as set. The erase or program frame follows. After it, status reads repeat until the write-in-progress flag (status bit 0) reads as clear. Each polling phase has its own budget of `POLL_LIMIT` reads. When the budget runs out, the run ends with a timeout. A status byte of 0xFF is taken to mean that no device is driving MISO, and the run ends with an I/O error. Any failure ends the run at once, and no further frames are sent.

The controller states are IDLE, WREN, POLL_OP, POLL_RD, CHECK, CMD, FETCH and DATA. Its transitions are:
- IDLE goes to WREN on start.
- WREN goes to POLL_OP when its byte is sent.
- POLL_OP goes to POLL_RD when its byte is sent.
- POLL_RD goes to CHECK when its byte is sent.
- CHECK goes to IDLE on a fault (error), on a spent budget (timeout) or after the last page (done). It goes to CMD when the latch matches, to WREN for the next operation when the busy flag clears, and back to POLL_OP when there is no match.
- CMD goes to POLL_OP after the erase address, or to FETCH after the program address.
- FETCH goes to DATA.
- DATA goes to FETCH for the next byte, or to POLL_OP after the 256th byte.

The byte engine has its own states: idle, low phase, high phase, hold (chip select kept low between bytes of one frame) and gap.

Top module: `flash_sector_rewriter`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, and busy, done, timeout and error are all 0.
- R2: The SPI link runs in mode 0. Data goes MSB first, MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge. cs_n stays 0 for a whole frame and stays 1 for at least 2*CLK_DIV clock cycles between frames. SCLK is 0 whenever cs_n is 1.
- R3: Before the erase and before each page program, the block sends a one-byte frame 0x06. It then sends status frames (0x05 followed by one dummy byte) until a status byte has bit 1 set.
- R4: The erase is a four-byte frame: 0x20 followed by the 24-bit address sector*4096, sent most significant byte first. It is sent once per run, before any program frame.
- R5: Sixteen program frames follow the erase, for pages 0 to 15 in ascending order. Each frame is 0x02, the 24-bit address sector*4096+page*256, and then 256 data bytes. Data byte b of page p is the byte the buffer returns on the cycle after buf_rd is asserted with buf_addr = p*256+b.
- R6: After the erase and after each program, the block sends status frames until a status byte has bit 0 clear. The poll budget restarts for every polling phase, so a match on the POLL_LIMIT-th read still succeeds.
- R7: If POLL_LIMIT status reads in one phase all fail to match, timeout is raised and no further frame is sent.
- R8: A status byte of 0xFF raises error at once, before the match test, and no further frame is sent.
- R9: At most one of done, timeout and error is 1. All three are 0 while busy, and the one that was set holds until the next start is accepted. A start pulse seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to rewrite a sector |
| sector | input | 12 | Sector number, sampled with start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run completed |
| timeout | output | 1 | The last run ran out of its poll budget |
| error | output | 1 | The last run read an all-ones status |
| buf_rd | output | 1 | Sector buffer read request |
| buf_addr | output | 12 | Sector buffer byte address |
| buf_data | input | 8 | Buffer data, valid one cycle after buf_rd |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench sets the erase busy time so that the write-in-progress flag clears on exactly the POLL_LIMIT-th read. A design that shares one poll budget across phases, or that counts one read too few, reports timeout on a run that should succeed. The bench also makes three runs fail: one with the write-enable latch stuck at 0, one with erase busy longer than the budget, and one with page 0 programming busy too long. In each of these it checks the exact number of status frames and confirms that no erase or program frame follows the failure. A design that does not abort, or that polls one time too many, shows up in those counts. A run with the status stuck at 0xFF must end with error after one read, not with timeout. After the good run, every one of the 4096 bytes in the flash model is compared with the buffer pattern. This catches a skipped erase, since programming can only clear bits, and it catches a page offset or byte order that is off by one.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_ERASE = 8'h20;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] ST_FAULT = 8'hFF;

    typedef enum logic [2:0] {
        RW_IDLE, RW_WREN, RW_POLL_OP, RW_POLL_RD,
        RW_CHECK, RW_CMD, RW_FETCH, RW_DATA
    } rw_state_t;

    typedef enum logic [2:0] {
        EN_IDLE, EN_LOW, EN_HIGH, EN_HOLD, EN_GAP
    } eng_state_t;
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import flash_rw_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       last,
    output logic       ready,
    output logic       byte_done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic       cs_n
);
    localparam int CW = $clog2(2 * CLK_DIV + 1);
    localparam logic [CW-1:0] HALF_END = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] GAP_END  = CW'(2 * CLK_DIV - 1);

    eng_state_t    st;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;
    logic          last_q;
    logic          sclk_q;
    logic          cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= EN_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            sh_tx     <= '0;
            sh_rx     <= '0;
            last_q    <= 1'b0;
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            unique case (st)
                EN_IDLE, EN_HOLD: begin
                    if (go) begin
                        cs_q   <= 1'b0;
                        sh_tx  <= tx;
                        last_q <= last;
                        bitn   <= '0;
                        cnt    <= '0;
                        st     <= EN_LOW;
                    end
                end
                EN_LOW: begin
                    if (cnt == HALF_END) begin
                        cnt    <= '0;
                        sclk_q <= 1'b1;
                        sh_rx  <= {sh_rx[6:0], miso};
                        st     <= EN_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                EN_HIGH: begin
                    if (cnt == HALF_END) begin
                        cnt    <= '0;
                        sclk_q <= 1'b0;
                        if (bitn == 3'd7) begin
                            byte_done <= 1'b1;
                            if (last_q) begin
                                cs_q <= 1'b1;
                                st   <= EN_GAP;
                            end else begin
                                st <= EN_HOLD;
                            end
                        end else begin
                            sh_tx <= {sh_tx[6:0], 1'b0};
                            bitn  <= bitn + 1'b1;
                            st    <= EN_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                EN_GAP: begin
                    if (cnt == GAP_END) begin
                        cnt <= '0;
                        st  <= EN_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign ready = (st == EN_IDLE) || (st == EN_HOLD);
    assign rx    = sh_rx;
    assign sclk  = sclk_q;
    assign mosi  = sh_tx[7];
    assign cs_n  = cs_q;
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last_try
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (bump) cnt <= cnt + 1'b1;
    end

    assign last_try = (cnt == LAST);
endmodule

// File: rtl/flash_sector_rewriter.sv
module flash_sector_rewriter
    import flash_rw_pkg::*;
#(
    parameter int CLK_DIV      = 2,
    parameter int POLL_LIMIT   = 100000,
    parameter int ADDR_W       = 24,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [11:0] sector,
    output logic        busy,
    output logic        done,
    output logic        timeout,
    output logic        error,
    output logic        buf_rd,
    output logic [11:0] buf_addr,
    input  logic [7:0]  buf_data,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    localparam int BIDX_W = $clog2(PAGE_BYTES);
    localparam int PIDX_W = $clog2(SECTOR_PAGES);
    localparam int SECT_W = ADDR_W - BIDX_W - PIDX_W;
    localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(PAGE_BYTES - 1);
    localparam logic [PIDX_W-1:0] PIDX_LAST = PIDX_W'(SECTOR_PAGES - 1);

    rw_state_t         state, state_nx;
    logic              sent, is_prog, wait_wel;
    logic [PIDX_W-1:0] page;
    logic [1:0]        idx;
    logic [BIDX_W-1:0] bidx;
    logic [7:0]        status_q;
    logic [SECT_W-1:0] sector_q;
    logic              done_q, to_q, err_q;

    logic              eng_go, eng_last, eng_ready, eng_done;
    logic [7:0]        eng_tx, eng_rx;
    logic              poll_clr, poll_bump, last_try;
    logic              fault, match;
    logic [ADDR_W-1:0] op_addr;

    spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx), .last(eng_last),
        .ready(eng_ready), .byte_done(eng_done), .rx(eng_rx),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    poll_budget #(.LIMIT(POLL_LIMIT)) u_budget (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .bump(poll_bump), .last_try(last_try)
    );

    assign op_addr = {sector_q, page, {BIDX_W{1'b0}}};
    assign fault   = (status_q == ST_FAULT);
    assign match   = wait_wel ? status_q[1] : !status_q[0];

    assign poll_clr = eng_done && ((state == RW_WREN)
                   || (state == RW_CMD && idx == 2'd3 && !is_prog)
                   || (state == RW_DATA && bidx == BIDX_LAST));
    assign poll_bump = (state == RW_CHECK) && !fault && !match && !last_try;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RW_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            RW_IDLE:    if (start) state_nx = RW_WREN;
            RW_WREN:    if (eng_done) state_nx = RW_POLL_OP;
            RW_POLL_OP: if (eng_done) state_nx = RW_POLL_RD;
            RW_POLL_RD: if (eng_done) state_nx = RW_CHECK;
            RW_CHECK: begin
                if (fault)                 state_nx = RW_IDLE;
                else if (match && wait_wel) state_nx = RW_CMD;
                else if (match)
                    state_nx = (is_prog && page == PIDX_LAST) ? RW_IDLE : RW_WREN;
                else if (last_try)         state_nx = RW_IDLE;
                else                       state_nx = RW_POLL_OP;
            end
            RW_CMD:
                if (eng_done && idx == 2'd3) state_nx = is_prog ? RW_FETCH : RW_POLL_OP;
            RW_FETCH:   if (eng_ready) state_nx = RW_DATA;
            RW_DATA:
                if (eng_done) state_nx = (bidx == BIDX_LAST) ? RW_POLL_OP : RW_FETCH;
        endcase
    end

    // datapath and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent <= 1'b0; is_prog <= 1'b0; wait_wel <= 1'b0;
            page <= '0; idx <= '0; bidx <= '0; status_q <= '0; sector_q <= '0;
            done_q <= 1'b0; to_q <= 1'b0; err_q <= 1'b0;
        end else begin
            if (eng_go)   sent <= 1'b1;
            if (eng_done) sent <= 1'b0;
            unique case (state)
                RW_IDLE: if (start) begin
                    sector_q <= sector;
                    page     <= '0;
                    is_prog  <= 1'b0;
                    idx      <= '0;
                    done_q   <= 1'b0;
                    to_q     <= 1'b0;
                    err_q    <= 1'b0;
                end
                RW_WREN:    if (eng_done) wait_wel <= 1'b1;
                RW_POLL_RD: if (eng_done) status_q <= eng_rx;
                RW_CHECK: begin
                    if (fault) err_q <= 1'b1;
                    else if (match && !wait_wel) begin
                        if (!is_prog)               is_prog <= 1'b1;
                        else if (page == PIDX_LAST) done_q  <= 1'b1;
                        else                        page    <= page + 1'b1;
                    end else if (!match && last_try) to_q <= 1'b1;
                end
                RW_CMD: if (eng_done) begin
                    idx <= idx + 1'b1;
                    if (idx == 2'd3) begin
                        bidx <= '0;
                        if (!is_prog) wait_wel <= 1'b0;
                    end
                end
                RW_DATA: if (eng_done) begin
                    bidx <= bidx + 1'b1;
                    if (bidx == BIDX_LAST) wait_wel <= 1'b0;
                end
                RW_POLL_OP, RW_FETCH: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        eng_go   = 1'b0;
        eng_tx   = 8'h00;
        eng_last = 1'b0;
        buf_rd   = 1'b0;
        unique case (state)
            RW_WREN:    begin eng_go = !sent && eng_ready; eng_tx = OP_WREN; eng_last = 1'b1; end
            RW_POLL_OP: begin eng_go = !sent && eng_ready; eng_tx = OP_RDSR; end
            RW_POLL_RD: begin eng_go = !sent && eng_ready; eng_last = 1'b1; end
            RW_CMD: begin
                eng_go   = !sent && eng_ready;
                eng_last = (idx == 2'd3) && !is_prog;
                unique case (idx)
                    2'd0: eng_tx = is_prog ? OP_PROG : OP_ERASE;
                    2'd1: eng_tx = op_addr[23:16];
                    2'd2: eng_tx = op_addr[15:8];
                    2'd3: eng_tx = op_addr[7:0];
                endcase
            end
            RW_FETCH:   buf_rd = eng_ready;
            RW_DATA:    begin eng_go = !sent && eng_ready; eng_tx = buf_data; eng_last = (bidx == BIDX_LAST); end
            RW_IDLE, RW_CHECK: ;
        endcase
    end

    assign buf_addr = {page, bidx};
    assign busy     = (state != RW_IDLE);
    assign done     = done_q;
    assign timeout  = to_q;
    assign error    = err_q;
endmodule

// File: rtl/flash_rewrite_checker.sv
module flash_rewrite_checker #(
    parameter int CLK_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic error,
    input logic buf_rd,
    input logic sclk,
    input logic cs_n
);
    localparam int GW = $clog2(2 * CLK_DIV + 2);
    localparam logic [GW-1:0] GAP_MIN = GW'(2 * CLK_DIV);

    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   gap_cnt <= GAP_MIN;
        else if (!cs_n)               gap_cnt <= '0;
        else if (gap_cnt != GAP_MIN)  gap_cnt <= gap_cnt + 1'b1;
    end

    // R1 / R2: link is quiet outside a run, clock idles low
    a_r1_idle_cs: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
    a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
    // R2: deselect gap between frames
    a_r2_cs_gap: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> gap_cnt >= GAP_MIN);
    // R5: buffer is read only inside a program frame
    a_r5_buf_in_frame: assert property (@(posedge clk) disable iff (!rst_n) buf_rd |-> !cs_n);
    // R7 / R8: failure leaves the link deselected
    a_r7_timeout_quiet: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout) |-> cs_n);
    a_r8_error_quiet: assert property (@(posedge clk) disable iff (!rst_n) $rose(error) |-> cs_n);
    // R9: one outcome at most, none during a run, held while idle
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, timeout, error}));
    a_r9_clear_busy: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !(done || timeout || error));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({done, timeout, error}));
endmodule

bind flash_sector_rewriter flash_rewrite_checker #(.CLK_DIV(CLK_DIV)) u_rw_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .timeout(timeout), .error(error), .buf_rd(buf_rd), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/test_flash_sector_rewriter.sv
module test_flash_sector_rewriter;
    localparam int CLK_DIV = 1;
    localparam int LIMIT   = 20;
    localparam logic [11:0] SECT = 12'h5A3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
    logic [11:0] sector = '0;
    logic busy, done, timeout, error, buf_rd, sclk, mosi, cs_n;
    logic [11:0] buf_addr;
    logic [7:0]  buf_data = '0;

    always #2 clk = ~clk;

    flash_sector_rewriter #(.CLK_DIV(CLK_DIV), .POLL_LIMIT(LIMIT)) i_flash_sector_rewriter (
        .clk(clk), .rst_n(rst_n), .start(start), .sector(sector), .busy(busy),
        .done(done), .timeout(timeout), .error(error), .buf_rd(buf_rd),
        .buf_addr(buf_addr), .buf_data(buf_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int total = 0, bad = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37) + ((i >> 8) * 11) + 5);
    endfunction

    always @(posedge clk) if (buf_rd) buf_data <= pat(int'(buf_addr));

    // flash model
    logic [7:0] fmem [4096];
    logic [7:0] frame [264];
    int nbytes = 0, bitc = 0;
    logic [7:0] inb = '0, out_sr = '0;
    logic wel = 1'b0;
    int busy_left = 0, erase_busy = 0, prog_busy = 0;
    logic stuck_wel0 = 1'b0, stuck_wip = 1'b0, fault_ff = 1'b0;
    int n_wren = 0, n_rdsr = 0, n_erase = 0, n_prog = 0, n_frames = 0, n_badf = 0;
    logic [23:0] erase_addr = '0;

    function automatic logic [7:0] status_now();
        if (fault_ff) return 8'hFF;
        return {6'b0, wel, stuck_wip || (busy_left > 0)};
    endfunction

    always @(negedge cs_n) begin nbytes = 0; bitc = 0; out_sr = '0; end

    always @(posedge sclk) if (!cs_n) begin
        inb = {inb[6:0], mosi};
        bitc++;
        if (bitc == 8) begin
            if (nbytes < 264) frame[nbytes] = inb;
            if (nbytes == 0 && inb == 8'h05) out_sr = status_now();
            nbytes++;
            bitc = 0;
        end
    end

    always @(negedge sclk) if (!cs_n) begin miso = out_sr[7]; out_sr = out_sr << 1; end

    always @(posedge cs_n) if (nbytes > 0) begin
        logic [23:0] a;
        a = {frame[1], frame[2], frame[3]};
        n_frames++;
        if (bitc != 0) n_badf++;
        case (frame[0])
            8'h06: begin n_wren++; if (nbytes != 1) n_badf++; if (!stuck_wel0) wel = 1'b1; end
            8'h05: begin n_rdsr++; if (nbytes != 2) n_badf++; if (busy_left > 0) busy_left--; end
            8'h20: begin
                n_erase++; erase_addr = a;
                if (nbytes != 4 || n_prog != 0 || a != {SECT, 12'h000}) n_badf++;
                if (wel) for (int i = 0; i < 4096; i++) fmem[i] = 8'hFF;
                wel = 1'b0; busy_left = erase_busy;
            end
            8'h02: begin
                if (nbytes != 260 || a != {SECT, 4'(n_prog), 8'h00}) n_badf++;
                n_prog++;
                if (wel) for (int i = 0; i < 256; i++)
                    fmem[{a[11:8], 8'(i)}] = fmem[{a[11:8], 8'(i)}] & frame[4 + i];
                wel = 1'b0; busy_left = prog_busy;
            end
            default: n_badf++;
        endcase
    end

    // bench-side measurement of the deselect gap (R2)
    int hi_run = 1000, min_gap = 1000;
    always @(posedge clk) begin
        if (cs_n) hi_run++;
        else begin
            if (hi_run != 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_wren = 0; n_rdsr = 0; n_erase = 0; n_prog = 0; n_frames = 0; n_badf = 0;
        wel = 1'b0; busy_left = 0;
    endtask

    task automatic run(input logic [11:0] s);
        @(negedge clk); sector = s; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int fr;
        for (int i = 0; i < 4096; i++) fmem[i] = pat(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0); chk("R1 busy", busy, 0);
        chk("R1 flags", {done, timeout, error}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // full rewrite; erase clears on exactly the LIMIT-th poll (R6 boundary)
        clear_counts(); erase_busy = LIMIT - 1; prog_busy = 2;
        fork
            run(SECT);
            begin repeat (600) @(negedge clk); sector = 12'h111; start = 1'b1;
                  @(negedge clk); start = 1'b0; end
        join
        chk("R9 done", {done, timeout, error}, 3'b100);
        chk("R3 wren frames", n_wren, 17);
        chk("R4 erase count", n_erase, 1);
        chk("R4 erase addr", erase_addr, {SECT, 12'h000});
        chk("R5 program count", n_prog, 16);
        chk("R6 status reads", n_rdsr, 1 + LIMIT + 16 * 4);
        chk("R2 frame shape", n_badf, 0);
        chk("R2 min gap ok", min_gap >= 2 * CLK_DIV, 1);
        for (int i = 0; i < 4096; i++) chk("R5 flash byte", fmem[i], pat(i));
        repeat (50) @(negedge clk);
        chk("R9 done held", {done, timeout, error}, 3'b100);

        // R7: latch never sets
        clear_counts(); stuck_wel0 = 1'b1;
        @(negedge clk); sector = SECT; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R9 cleared on start", {done, timeout, error}, 0);
        while (busy) @(negedge clk);
        fr = n_frames;
        repeat (100) @(negedge clk);
        chk("R7 wel timeout flag", {done, timeout, error}, 3'b010);
        chk("R7 wel poll count", n_rdsr, LIMIT);
        chk("R7 no erase", n_erase, 0);
        chk("R7 no frames after", n_frames, fr);
        stuck_wel0 = 1'b0;

        // R7: erase busy past the budget
        clear_counts(); erase_busy = LIMIT;
        run(SECT);
        chk("R7 erase timeout", {done, timeout, error}, 3'b010);
        chk("R7 erase polls", n_rdsr, 1 + LIMIT);
        chk("R7 no program", n_prog, 0);
        chk("R7 single wren", n_wren, 1);

        // R7: first page program busy past the budget
        clear_counts(); erase_busy = 0; prog_busy = LIMIT + 5;
        run(SECT);
        chk("R7 page timeout", {done, timeout, error}, 3'b010);
        chk("R7 page program count", n_prog, 1);
        chk("R7 page polls", n_rdsr, 2 + 1 + LIMIT);

        // R8: all-ones status
        clear_counts(); fault_ff = 1'b1;
        run(SECT);
        fr = n_frames;
        repeat (100) @(negedge clk);
        chk("R8 error flag", {done, timeout, error}, 3'b001);
        chk("R8 single poll", n_rdsr, 1);
        chk("R8 no erase", n_erase, 0);
        chk("R8 no frames after", n_frames, fr);
        chk("R1 idle cs", cs_n, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule